// File: doc/BRIEF.md
# Configurable Multi-Byte Serial Register Reader

This block runs serial transfers against a sixteen-entry byte register file that sits outside it. A transfer starts with a one-cycle start pulse that carries a direction flag, a 4-bit start address and a byte count. It then moves one bit on every rising edge of a slow serial clock. The serial clock is sampled in the block's own clock domain.

On reads, three settings are captured at the start of the transfer:
- Byte order chooses whether the address steps up or down from the start address.
- Bit order chooses which end of each byte leaves first.
- Output select chooses the pin that carries the data: either the shared bidirectional pin or a dedicated output pin. Each pin has its own output enable.

Writes ignore all three settings. A write always shifts in most significant bit first and steps upward through the addresses. Each completed byte is committed to the register file with a one-cycle write strobe.

Top module: `srr_serial_reader`

## Requirements
- R1: While idle, a cycle with `start_i` high captures `rw_i` (1 = read, 0 = write), `addr_i`, `len_i` and the three settings, and `busy_o` is high from the next cycle. A start pulse while busy is ignored: the running transfer continues unchanged and no write strobe results.
- R2: With byte order 0, byte j of a read comes from address (start + j) mod 16.
- R3: With byte order 1, byte j of a read comes from address (start − j) mod 16.
- R4: With bit order 0, each read byte is sent bit 7 first and bit 0 last. With bit order 1 it is sent bit 0 first and bit 7 last.
- R5: With output select 0, read bits appear on `sdio_o` with `sdio_oe_o` high, and `sdout_oe_o` stays low throughout.
- R6: With output select 1, read bits appear on `sdout_o` with `sdout_oe_o` high, and `sdio_oe_o` stays low throughout.
- R7: A bit is consumed on each clock cycle in which `sclk_i` is high and was low at the previous clock edge. A high level held over several cycles consumes only one bit. The bit currently being sent is taken combinationally from `rf_rdata_i` at `rf_addr_o`.
- R8: Both output enables are low whenever no read bit is being sent, which covers idle time and writes.
- R9: A write samples `sdio_i` on each consumed edge, most significant bit first. Byte k is written to address (start + k) mod 16 whatever the settings are. `rf_we_o` pulses for exactly one cycle, in the cycle after the edge of the byte's eighth bit.
- R10: `len_i` holds the byte count minus one (0 means 1 byte, 15 means 16 bytes). `busy_o` drops in the cycle after the edge that consumes the last bit.
- R11: During and after reset, `busy_o`, `sdio_oe_o`, `sdout_oe_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer start pulse |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 4 | Start address |
| len_i | input | 4 | Byte count minus one |
| cfg_byte_rev_i | input | 1 | Byte order: 1 = addresses step downward on reads |
| cfg_bit_rev_i | input | 1 | Bit order: 1 = least significant bit first on reads |
| cfg_out_sel_i | input | 1 | Output select: 1 = dedicated output pin |
| sclk_i | input | 1 | Serial clock, sampled |
| sdio_i | input | 1 | Shared pin, input side |
| sdio_o | output | 1 | Shared pin, output value |
| sdio_oe_o | output | 1 | Shared pin output enable |
| sdout_o | output | 1 | Dedicated output pin value |
| sdout_oe_o | output | 1 | Dedicated output pin enable |
| busy_o | output | 1 | Transfer in progress |
| rf_addr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |

## Verification
The bench sweeps every combination of the three settings across all sixteen start addresses. For each, it runs one-byte, two-byte and full sixteen-byte reads, so the address wraps past both ends in both directions. A counter that stepped the wrong way or failed to wrap would return bytes from the wrong addresses, and a bit select mirrored the wrong way would return bytes reversed bit for bit. Writes are issued with every read setting asserted and then read back with the defaults, which catches a write path that wrongly honours the read settings. The bench also holds the serial clock high across several cycles to catch a design that consumes bits on level rather than on edge. It fires a start pulse in the middle of a read to catch a design that restarts the transfer or writes spuriously.

// File: rtl/srr_pkg.sv
package srr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } srr_state_e;

  typedef struct packed {
    logic byte_rev;  // 1: read addresses step downward
    logic bit_rev;   // 1: least significant bit leaves first
    logic out_sel;   // 1: dedicated output pin carries read data
  } srr_cfg_t;

endpackage

// File: rtl/srr_rst_sync.sv
module srr_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/srr_addr_ctr.sv
module srr_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_n;

  // Natural modulo-2^ADDR_W arithmetic provides the wrap at both ends.
  always_comb begin
    addr_n = addr_q;
    if (load_i)      addr_n = load_addr_i;
    else if (step_i) addr_n = down_i ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_q <= '0;
    else if (load_i || step_i) addr_q <= addr_n;
  end

  assign addr_o = addr_q;

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !down_i && !load_i) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && down_i && !load_i) |=> addr_q == ADDR_W'($past(addr_q) - 1'b1));
endmodule

// File: rtl/srr_seq.sv
module srr_seq
  import srr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] len_i,
  input  srr_cfg_t          cfg_i,
  input  logic              rise_i,
  output srr_state_e        state_o,
  output srr_cfg_t          cfg_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              load_o,
  output logic              byte_end_o,
  output logic              down_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  srr_state_e        state_q, state_n;
  srr_cfg_t          cfg_q, cfg_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [ADDR_W-1:0] left_q, left_n;
  logic              load, byte_end;

  always_comb begin
    state_n  = state_q;
    cfg_n    = cfg_q;
    bit_n    = bit_q;
    left_n   = left_q;
    load     = 1'b0;
    byte_end = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          cfg_n   = cfg_i;
          left_n  = len_i;
          bit_n   = '0;
          state_n = rw_i ? ST_READ : ST_WRITE;
        end
      end
      default: begin
        if (rise_i) begin
          if (bit_q == LAST_BIT) begin
            byte_end = 1'b1;
            bit_n    = '0;
            if (left_q == '0) state_n = ST_IDLE;
            else              left_n  = left_q - 1'b1;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      bit_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_n;
      if (load) cfg_q <= cfg_n;
      if (load || rise_i) begin
        bit_q  <= bit_n;
        left_q <= left_n;
      end
    end
  end

  assign state_o    = state_q;
  assign cfg_o      = cfg_q;
  assign bit_o      = bit_q;
  assign load_o     = load;
  assign byte_end_o = byte_end;
  // Only reads may walk downward; writes always climb.
  assign down_o     = (state_q == ST_READ) && cfg_q.byte_rev;

  a_r7_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && rise_i && bit_q != LAST_BIT) |=> bit_q == BIT_W'($past(bit_q) + 1'b1));

  a_r7_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !rise_i) |=> $stable(bit_q) && state_q == $past(state_q));

  a_r10_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && rise_i && bit_q == LAST_BIT && left_q == '0) |=> state_q == ST_IDLE);

  a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i && !rise_i) |=> state_q == $past(state_q) && $stable(cfg_q));
endmodule

// File: rtl/srr_wr_shift.sv
module srr_wr_shift #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              commit_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [BYTE_W-1:0] wdata_q, wdata_n;

  // Fixed MSB-first assembly: earliest bit ends in the top position.
  always_comb begin
    sh_n    = {sh_q[BYTE_W-3:0], bit_i};
    wdata_n = {sh_q, bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= commit_i;
      if (shift_i) sh_q <= sh_n;
      if (commit_i) begin
        waddr_q <= addr_i;
        wdata_q <= wdata_n;
      end
    end
  end

  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;

  a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  a_r9_we_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(commit_i) && $past(shift_i));
endmodule

// File: rtl/srr_pins.sv
module srr_pins
  import srr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  srr_state_e       state_i,
  input  srr_cfg_t         cfg_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic             sdio_o,
  output logic             sdio_oe_o,
  output logic             sdout_o,
  output logic             sdout_oe_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0] sel;
  logic             rd_bit, reading;

  always_comb begin
    sel        = cfg_i.bit_rev ? bit_i : LAST_BIT - bit_i;
    rd_bit     = rdata_i[sel];
    reading    = (state_i == ST_READ);
    sdio_oe_o  = reading && !cfg_i.out_sel;
    sdout_oe_o = reading &&  cfg_i.out_sel;
    sdio_o     = sdio_oe_o  && rd_bit;
    sdout_o    = sdout_oe_o && rd_bit;
  end
endmodule

// File: rtl/srr_serial_reader.sv
module srr_serial_reader
  import srr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              cfg_byte_rev_i,
  input  logic              cfg_bit_rev_i,
  input  logic              cfg_out_sel_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdout_o,
  output logic              sdout_oe_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  input  logic [BYTE_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_waddr_o,
  output logic [BYTE_W-1:0] rf_wdata_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              rst_n;
  logic              sclk_q, rise;
  srr_cfg_t          cfg_in, cfg;
  srr_state_e        state;
  logic [BIT_W-1:0]  bit_idx;
  logic              load, byte_end, down;
  logic [ADDR_W-1:0] addr;

  srr_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end
  assign rise = sclk_i && !sclk_q;

  assign cfg_in = '{byte_rev: cfg_byte_rev_i, bit_rev: cfg_bit_rev_i, out_sel: cfg_out_sel_i};

  srr_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i), .len_i(len_i),
    .cfg_i(cfg_in), .rise_i(rise), .state_o(state), .cfg_o(cfg), .bit_o(bit_idx),
    .load_o(load), .byte_end_o(byte_end), .down_o(down)
  );

  srr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_addr_i(addr_i),
    .step_i(byte_end), .down_i(down), .addr_o(addr)
  );

  srr_wr_shift #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .shift_i(rise && state == ST_WRITE),
    .commit_i(byte_end && state == ST_WRITE), .bit_i(sdio_i), .addr_i(addr),
    .we_o(rf_we_o), .waddr_o(rf_waddr_o), .wdata_o(rf_wdata_o)
  );

  srr_pins #(.BYTE_W(BYTE_W)) u_pins (
    .state_i(state), .cfg_i(cfg), .bit_i(bit_idx), .rdata_i(rf_rdata_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o)
  );

  assign busy_o    = (state != ST_IDLE);
  assign rf_addr_o = addr;

  a_r5_dedicated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.out_sel |-> !sdout_oe_o);

  a_r6_shared_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.out_sel |-> !sdio_oe_o);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ) |-> (!sdio_oe_o && !sdout_oe_o));

  a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |-> !rf_we_o);
endmodule

// File: tb/srr_serial_reader_tb.sv
`timescale 1ns/1ps
module srr_serial_reader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, rw, byte_rev, bit_rev, out_sel, sclk, sdio_in;
  logic [3:0] addr_in, len_in;
  logic       sdio_out, sdio_oe, sdout_out, sdout_oe, busy;
  logic [3:0] rf_addr, rf_waddr;
  logic [7:0] rf_rdata, rf_wdata;
  logic       rf_we;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  int n_tests = 0, n_fail = 0;
  int we_cnt = 0, we_in_read = 0;
  logic in_read = 1'b0;

  always #4 clk = ~clk;

  srr_serial_reader dut_i (
    .clk(clk), .rst_ni(rst_n), .start_i(start), .rw_i(rw), .addr_i(addr_in), .len_i(len_in),
    .cfg_byte_rev_i(byte_rev), .cfg_bit_rev_i(bit_rev), .cfg_out_sel_i(out_sel),
    .sclk_i(sclk), .sdio_i(sdio_in), .sdio_o(sdio_out), .sdio_oe_o(sdio_oe),
    .sdout_o(sdout_out), .sdout_oe_o(sdout_oe), .busy_o(busy),
    .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) begin
    if (rf_we) begin
      mem[rf_waddr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
      if (in_read) we_in_read <= we_in_read + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'(seed * 29 + j * 53 + 7);
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [3:0] n, input int seed,
                          input logic [2:0] cfg);
    int oe_err = 0;
    int we0;
    logic [7:0] d;
    @(negedge clk);
    start = 1'b1; rw = 1'b0; addr_in = a; len_in = n;
    {byte_rev, bit_rev, out_sel} = cfg;
    @(negedge clk);
    start = 1'b0;
    we0 = we_cnt;
    chk(busy === 1'b1, "R1 busy after write start", int'(busy), 1);
    for (int j = 0; j <= int'(n); j++) begin
      d = pat(seed, j);
      for (int k = 0; k < 8; k++) begin
        sdio_in = d[7-k];
        if (sdio_oe !== 1'b0 || sdout_oe !== 1'b0) oe_err++;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
      end
      exp_mem[4'(a + j)] = d;
    end
    @(negedge clk);
    chk(oe_err == 0, "R8 pins released during write", oe_err, 0);
    chk(busy === 1'b0, "R10 idle after write", int'(busy), 0);
    chk(we_cnt - we0 == int'(n) + 1, "R9 one strobe per byte", we_cnt - we0, int'(n) + 1);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [3:0] n, input logic [2:0] cfg,
                         input int hold, input bit inject);
    int oe_err = 0;
    logic [7:0] got;
    logic [3:0] ea;
    logic b;
    @(negedge clk);
    start = 1'b1; rw = 1'b1; addr_in = a; len_in = n;
    {byte_rev, bit_rev, out_sel} = cfg;
    @(negedge clk);
    start = 1'b0;
    in_read = 1'b1;
    chk(busy === 1'b1, "R1 busy after read start", int'(busy), 1);
    // The scrambled inputs must not matter once captured.
    {byte_rev, bit_rev, out_sel} = ~cfg;
    for (int j = 0; j <= int'(n); j++) begin
      got = '0;
      for (int k = 0; k < 8; k++) begin
        if (cfg[0]) begin
          b = sdout_out;
          if (sdout_oe !== 1'b1 || sdio_oe !== 1'b0) oe_err++;
        end else begin
          b = sdio_out;
          if (sdio_oe !== 1'b1 || sdout_oe !== 1'b0) oe_err++;
        end
        got[cfg[1] ? k : 7 - k] = b;
        if (j == int'(n) && k == 7)
          chk(busy === 1'b1, "R10 busy before last edge", int'(busy), 1);
        sclk = 1'b1;
        if (inject && j == 0 && k == 3) begin
          start = 1'b1; rw = 1'b0; addr_in = a + 4'd5;
        end
        @(negedge clk);
        start = 1'b0;
        for (int h = 0; h < hold; h++) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
      end
      ea = cfg[2] ? 4'(a - j) : 4'(a + j);
      chk(got === exp_mem[ea],
          cfg[2] ? "R3/R4/R7 descending read byte" : "R2/R4/R7 ascending read byte",
          int'(got), int'(exp_mem[ea]));
    end
    chk(oe_err == 0, cfg[0] ? "R6 dedicated pin drive" : "R5 shared pin drive", oe_err, 0);
    chk(busy === 1'b0, "R10 idle after last bit", int'(busy), 0);
    chk(sdio_oe === 1'b0 && sdout_oe === 1'b0, "R8 released after read",
        int'({sdio_oe, sdout_oe}), 0);
    in_read = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rw = 1'b0; addr_in = '0; len_in = '0;
    byte_rev = 1'b0; bit_rev = 1'b0; out_sel = 1'b0; sclk = 1'b0; sdio_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && sdio_oe === 1'b0 && sdout_oe === 1'b0 && rf_we === 1'b0,
        "R11 outputs in reset", int'({busy, sdio_oe, sdout_oe, rf_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && sdio_oe === 1'b0 && sdout_oe === 1'b0 && rf_we === 1'b0,
        "R11 outputs after reset", int'({busy, sdio_oe, sdout_oe, rf_we}), 0);

    // Fill the file with every read setting raised: writes must ignore them (R9).
    do_write(4'd0, 4'd15, 1, 3'b111);

    // Sweep all settings, all start addresses, 1/2/16-byte reads (R2..R7, R10).
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        do_read(4'(a), 4'd0, 3'(c), a % 3, 1'b0);
        do_read(4'(a), 4'd1, 3'(c), 0, 1'b0);
        do_read(4'(a), 4'd15, 3'(c), 0, 1'b0);
      end
    end

    // Wrapping write with reversed settings, then full readback (R9).
    do_write(4'd14, 4'd3, 9, 3'b101);
    do_read(4'd0, 4'd15, 3'b000, 0, 1'b0);
    do_write(4'd3, 4'd0, 17, 3'b110);
    do_read(4'd15, 4'd15, 3'b100, 1, 1'b0);

    // Start pulse mid-read must be ignored (R1).
    do_read(4'd6, 4'd2, 3'b011, 0, 1'b1);
    do_read(4'd1, 4'd2, 3'b100, 0, 1'b1);
    chk(we_in_read == 0, "R1 no write strobe from ignored start", we_in_read, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule